// File: doc/BRIEF.md
# Spread-Spectrum Divisor Modulation Sequencer

This block produces the feedback divisor for a clock synthesizer's PLL with a slowly varying offset added, so that the output frequency sweeps across a narrow band and its spectral energy is spread out. The offset walks one unit at a time along a triangular path. The time spent on each value is a programmable number of dwell units, and each unit is a fixed number of system-clock cycles. Two profile sources are offered. In table mode the walk is a fixed down-only sweep about 0.5 % deep, and its depth is derived from the base divisor. In programmable mode the walk climbs to a positive limit and then falls to a negative limit. The two limits are set independently, so the triangle may be asymmetric. The negative limit arrives in two's complement form.

A second divisor path, used for a serial-storage reference clock, can receive the same offset under its own enable. When the global enable is low, both divisors pass through unchanged in the same cycle, and the walk restarts from zero on the next enable. The analog loop and the charge pump lie outside this block.

Top module: `spread_mod_seq`

## Requirements
- R1: While `spread_en` is 0, `div_out` equals `base_div` and `sata_div_out` equals `sata_base` in the same cycle. When spreading is enabled again, the walk restarts from offset 0 with the upward direction.
- R2: With `mn_mode` = 0 the profile is a down-only triangle between 0 and -D, where D = floor(`base_div` * 41 / 8192), about 0.5 % of the divisor. The first step goes to -1. The walk reaches -D after D steps and is back at 0 after 2D steps.
- R3: With `mn_mode` = 1 the offset rises by 1 per step until it reaches +U, where U is the unsigned value of `up_code`. It then falls by 1 per step until it reaches -M, turns around without a pause step, and repeats with a period of 2(U+M) steps. The offset never changes by more than 1 per clock.
- R4: M is the 4-bit two's complement negation of `down_code`: 1111 gives 1, 1110 gives 2, 1011 gives 5, 1001 gives 7, 1000 gives 8, and 0000 gives 0.
- R5: A step happens once every `dwell` × CYC_PER_UNIT clock cycles (CYC_PER_UNIT is 56 by default, which is 280 ns at 200 MHz). The first step after enable lands on that many rising edges after `spread_en` is seen high. When `dwell` = 0, the offset is frozen.
- R6: `sata_div_out` equals `sata_base` plus the offset only while both `sata_spread_en` and `spread_en` are 1. Otherwise it equals `sata_base`.
- R7: In programmable mode with `up_code` = 0 and `down_code` = 0000, the offset stays at 0.
- R8: `div_out` equals `base_div` plus the signed offset, modulo 2^N_W. A change of `base_div` appears on `div_out` in the same cycle.
- R9: After reset the offset is 0 and the walk direction is upward, so with U > 0 the first step goes to +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | Global spreading enable |
| mn_mode | input | 1 | 1 = programmable triangle, 0 = fixed table-mode down spread |
| sata_spread_en | input | 1 | Applies the offset to the second divisor path |
| up_code | input | 4 | Upper limit U of the programmable triangle |
| down_code | input | 4 | Lower limit magnitude, two's complement coded |
| dwell | input | DW_W (6) | Dwell units per step; 0 freezes the walk |
| base_div | input | N_W (11) | Unmodulated main divisor |
| sata_base | input | N_W (11) | Unmodulated second-path divisor |
| div_out | output | N_W (11) | Modulated main divisor |
| sata_div_out | output | N_W (11) | Second-path divisor, modulated when enabled |

## Verification
Three events can fall in the same cycle: a dwell tick that moves the offset, a change of `base_div`, and a drop of `spread_en`. The sum seen on `div_out` must then reflect the new base together with either the stepped offset or no offset at all. The bench changes the base and drops the enable at clock edges between ticks and checks the output combinationally after each one. It also counts edges so that every sample lands exactly one edge before a tick or right on it. A turnaround step at a limit and a limit change are both judged from the offset sequence read back as `div_out - base_div`.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;

   typedef enum logic {
      DIR_UP = 1'b0,
      DIR_DN = 1'b1
   } ssc_dir_e;

   // Magnitude of a two's complement coded lower limit (4-bit negation).
   function automatic logic [4:0] down_mag(input logic [3:0] code);
      logic [3:0] neg;
      neg = 4'(~code + 4'd1);
      return {1'b0, neg};
   endfunction

endpackage

// File: rtl/ssc_dwell_timer.sv
`timescale 1ns/1ps
module ssc_dwell_timer #(
   parameter int DW_W         = 6,
   parameter int CYC_PER_UNIT = 56
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [DW_W-1:0] dwell,
   output logic            tick
);
   localparam int CPU_W = $clog2(CYC_PER_UNIT + 1);
   localparam int CNT_W = DW_W + CPU_W;

   if (CYC_PER_UNIT < 1) begin : g_bad_unit
      $error("CYC_PER_UNIT must be at least 1");
   end

   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] cnt;

   if (CYC_PER_UNIT == 1) begin : g_unit
      assign lim = CNT_W'(dwell);
   end else begin : g_scaled
      assign lim = CNT_W'(dwell) * CNT_W'(CYC_PER_UNIT);
   end

   assign tick = en && (lim != '0) && (cnt >= lim - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en || lim == '0 || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ssc_limits.sv
`timescale 1ns/1ps
module ssc_limits
   import ssc_pkg::*;
#(
   parameter int N_W       = 11,
   parameter int LIM_W     = 5,
   parameter int FIX_MUL   = 41,
   parameter int FIX_SHIFT = 13
) (
   input  logic             mn_mode,
   input  logic [3:0]       up_code,
   input  logic [3:0]       down_code,
   input  logic [N_W-1:0]   base_div,
   output logic [LIM_W-1:0] up_lim,
   output logic [LIM_W-1:0] dn_lim
);
   localparam int MUL_W     = $clog2(FIX_MUL + 1) + 1;
   localparam int PROD_W    = N_W + MUL_W;
   localparam int MAX_DEPTH = ((2 ** N_W - 1) * FIX_MUL) >> FIX_SHIFT;

   if (LIM_W < 5) begin : g_bad_lim
      $error("LIM_W must hold the programmable limits 0..15");
   end
   if (MAX_DEPTH >= 2 ** LIM_W) begin : g_bad_depth
      $error("fixed spread depth overflows the limit width");
   end

   logic [LIM_W-1:0] fix_depth;

   if (FIX_MUL == 0) begin : g_no_fixed
      assign fix_depth = '0;
   end else begin : g_fixed
      logic [PROD_W-1:0] prod;
      assign prod      = PROD_W'(base_div) * PROD_W'(FIX_MUL);
      assign fix_depth = LIM_W'(prod >> FIX_SHIFT);
   end

   always_comb begin
      if (mn_mode) begin
         up_lim = LIM_W'(up_code);
         dn_lim = LIM_W'(down_mag(down_code));
      end else begin
         up_lim = '0;
         dn_lim = fix_depth;
      end
   end
endmodule

// File: rtl/ssc_tri_walker.sv
`timescale 1ns/1ps
module ssc_tri_walker
   import ssc_pkg::*;
#(
   parameter int OFS_W = 6,
   parameter int LIM_W = OFS_W - 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    tick,
   input  logic [LIM_W-1:0]        up_lim,
   input  logic [LIM_W-1:0]        dn_lim,
   output logic signed [OFS_W-1:0] ofs
);
   localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);

   if (LIM_W >= OFS_W) begin : g_bad_w
      $error("offset must be wider than its limits");
   end

   ssc_dir_e           dir;
   logic signed [OFS_W-1:0] hi, lo;
   logic               can_up, can_dn;

   assign hi     = $signed({{(OFS_W - LIM_W){1'b0}}, up_lim});
   assign lo     = -$signed({{(OFS_W - LIM_W){1'b0}}, dn_lim});
   assign can_up = ofs < hi;
   assign can_dn = ofs > lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs <= '0;
         dir <= DIR_UP;
      end else if (!en) begin
         ofs <= '0;
         dir <= DIR_UP;
      end else if (tick) begin
         if (dir == DIR_UP) begin
            if (can_up) begin
               ofs <= ofs + ONE;
            end else if (can_dn) begin
               ofs <= ofs - ONE;
               dir <= DIR_DN;
            end
         end else begin
            if (can_dn) begin
               ofs <= ofs - ONE;
            end else if (can_up) begin
               ofs <= ofs + ONE;
               dir <= DIR_UP;
            end
         end
      end
   end
endmodule

// File: rtl/spread_mod_seq.sv
`timescale 1ns/1ps
module spread_mod_seq #(
   parameter int N_W          = 11,
   parameter int OFS_W        = 6,
   parameter int DW_W         = 6,
   parameter int CYC_PER_UNIT = 56,
   parameter int FIX_MUL      = 41,
   parameter int FIX_SHIFT    = 13
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            spread_en,
   input  logic            mn_mode,
   input  logic            sata_spread_en,
   input  logic [3:0]      up_code,
   input  logic [3:0]      down_code,
   input  logic [DW_W-1:0] dwell,
   input  logic [N_W-1:0]  base_div,
   input  logic [N_W-1:0]  sata_base,
   output logic [N_W-1:0]  div_out,
   output logic [N_W-1:0]  sata_div_out
);
   localparam int LIM_W = OFS_W - 1;

   if (N_W < OFS_W) begin : g_bad_nw
      $error("divisor width must not be below the offset width");
   end

   logic                    tick;
   logic [LIM_W-1:0]        up_lim, dn_lim;
   logic signed [OFS_W-1:0] ofs;
   logic [N_W-1:0]          ofs_ext;

   ssc_dwell_timer #(.DW_W(DW_W), .CYC_PER_UNIT(CYC_PER_UNIT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (spread_en),
      .dwell (dwell),
      .tick  (tick)
   );

   ssc_limits #(.N_W(N_W), .LIM_W(LIM_W), .FIX_MUL(FIX_MUL), .FIX_SHIFT(FIX_SHIFT)) u_limits (
      .mn_mode   (mn_mode),
      .up_code   (up_code),
      .down_code (down_code),
      .base_div  (base_div),
      .up_lim    (up_lim),
      .dn_lim    (dn_lim)
   );

   ssc_tri_walker #(.OFS_W(OFS_W), .LIM_W(LIM_W)) u_walker (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (spread_en),
      .tick   (tick),
      .up_lim (up_lim),
      .dn_lim (dn_lim),
      .ofs    (ofs)
   );

   if (N_W == OFS_W) begin : g_same_w
      assign ofs_ext = ofs;
   end else begin : g_sext
      assign ofs_ext = {{(N_W - OFS_W){ofs[OFS_W-1]}}, ofs};
   end

   assign div_out      = base_div  + (spread_en ? ofs_ext : '0);
   assign sata_div_out = sata_base + ((spread_en && sata_spread_en) ? ofs_ext : '0);
endmodule

// File: rtl/spread_mod_seq_chk.sv
`timescale 1ns/1ps
module spread_mod_seq_chk #(
   parameter int N_W  = 11,
   parameter int DW_W = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            spread_en,
   input logic            mn_mode,
   input logic            sata_spread_en,
   input logic [3:0]      up_code,
   input logic [3:0]      down_code,
   input logic [DW_W-1:0] dwell,
   input logic [N_W-1:0]  base_div,
   input logic [N_W-1:0]  sata_base,
   input logic [N_W-1:0]  div_out,
   input logic [N_W-1:0]  sata_div_out
);
   localparam logic signed [N_W-1:0] ONE  = N_W'(1);
   localparam logic signed [N_W-1:0] ZERO = '0;

   logic signed [N_W-1:0] ofs_obs, sata_obs;
   logic                  zero_cfg;
   assign ofs_obs  = $signed(div_out - base_div);
   assign sata_obs = $signed(sata_div_out - sata_base);
   assign zero_cfg = spread_en && mn_mode && up_code == 4'd0 && down_code == 4'd0;

   AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      !spread_en |-> (ofs_obs == ZERO)); // R1

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (spread_en && $past(spread_en)) |->
      (ofs_obs == $past(ofs_obs) || ofs_obs == $past(ofs_obs) + ONE || ofs_obs == $past(ofs_obs) - ONE)); // R3

   AST_TABLE_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
      (spread_en && !mn_mode && $past(spread_en) && !$past(mn_mode) && $past(ofs_obs) <= ZERO)
      |-> (ofs_obs <= ZERO)); // R2

   AST_DWELL_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (spread_en && $past(spread_en) && $past(dwell) == '0) |-> (ofs_obs == $past(ofs_obs))); // R5

   AST_SATA_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      !(spread_en && sata_spread_en) |-> (sata_div_out == sata_base)); // R6

   AST_SATA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (spread_en && sata_spread_en) |-> (sata_obs == ofs_obs)); // R6

   AST_ZERO_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_cfg && $past(zero_cfg) && $past(ofs_obs) == ZERO) |-> (ofs_obs == ZERO)); // R7
endmodule

bind spread_mod_seq spread_mod_seq_chk #(.N_W(N_W), .DW_W(DW_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .spread_en      (spread_en),
   .mn_mode        (mn_mode),
   .sata_spread_en (sata_spread_en),
   .up_code        (up_code),
   .down_code      (down_code),
   .dwell          (dwell),
   .base_div       (base_div),
   .sata_base      (sata_base),
   .div_out        (div_out),
   .sata_div_out   (sata_div_out)
);

// File: tb/spread_mod_seq_test.sv
`timescale 1ns/1ps
module spread_mod_seq_test;
   localparam int N_W  = 11;
   localparam int UNIT = 56;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            spread_en = 1'b0;
   logic            mn_mode = 1'b1;
   logic            sata_spread_en = 1'b0;
   logic [3:0]      up_code = 4'd0;
   logic [3:0]      down_code = 4'b1011;
   logic [5:0]      dwell = 6'd1;
   logic [N_W-1:0]  base_div = 11'd1000;
   logic [N_W-1:0]  sata_base = 11'd500;
   logic [N_W-1:0]  div_out, sata_div_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   spread_mod_seq uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .spread_en      (spread_en),
      .mn_mode        (mn_mode),
      .sata_spread_en (sata_spread_en),
      .up_code        (up_code),
      .down_code      (down_code),
      .dwell          (dwell),
      .base_div       (base_div),
      .sata_base      (sata_base),
      .div_out        (div_out),
      .sata_div_out   (sata_div_out)
   );

   function automatic int cur_ofs();
      logic signed [N_W-1:0] d;
      d = $signed(div_out - base_div);
      return int'(d);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // wait a number of rising edges, then sample just after the following falling edge
   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic restart(input logic mode, input logic [3:0] up, input logic [3:0] dn, input logic [5:0] dw);
      @(negedge clk);
      spread_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      mn_mode   = mode;
      up_code   = up;
      down_code = dn;
      dwell     = dw;
      spread_en = 1'b1;
   endtask

   task automatic t_reset();
      edges(3);
      rst_n = 1'b1;
      edges(2);
      chk("R9", "div at reset", int'(div_out), 1000);
      chk("R9", "sata at reset", int'(sata_div_out), 500);
      restart(1'b1, 4'd3, 4'b1111, 6'd1);
      edges(UNIT - 1);
      chk("R5", "no step one edge early", cur_ofs(), 0);
      edges(0);
      repeat (1) @(posedge clk);
      @(negedge clk); #1;
      chk("R9", "first step upward", cur_ofs(), 1);
   endtask

   task automatic t_walk();
      int exp_w[11] = '{1, 2, 1, 0, -1, -2, -3, -2, -1, 0, 1};
      restart(1'b1, 4'd2, 4'b1101, 6'd1);
      for (int i = 0; i < 11; i++) begin
         edges(UNIT);
         chk("R3", $sformatf("walk step %0d", i + 1), cur_ofs(), exp_w[i]);
      end
   endtask

   task automatic t_decode();
      restart(1'b1, 4'd0, 4'b1000, 6'd1);
      edges(8 * UNIT);
      chk("R4", "code 1000 reaches -8", cur_ofs(), -8);
      edges(UNIT);
      chk("R4", "code 1000 turns at -8", cur_ofs(), -7);
      restart(1'b1, 4'd0, 4'b1111, 6'd1);
      edges(UNIT);
      chk("R4", "code 1111 step 1", cur_ofs(), -1);
      edges(UNIT);
      chk("R4", "code 1111 step 2", cur_ofs(), 0);
      edges(UNIT);
      chk("R4", "code 1111 step 3", cur_ofs(), -1);
   endtask

   task automatic t_table();
      base_div = 11'd1000;
      restart(1'b0, 4'd9, 4'b1111, 6'd1);
      edges(UNIT);
      chk("R2", "table first step", cur_ofs(), -1);
      edges(4 * UNIT);
      chk("R2", "table depth 5", cur_ofs(), -5);
      edges(UNIT);
      chk("R2", "table turn", cur_ofs(), -4);
      edges(4 * UNIT);
      chk("R2", "table back to 0", cur_ofs(), 0);
      edges(UNIT);
      chk("R2", "table repeat", cur_ofs(), -1);
      base_div = 11'd2000;
      restart(1'b0, 4'd0, 4'd0, 6'd1);
      edges(10 * UNIT);
      chk("R2", "table depth 10", cur_ofs(), -10);
      edges(UNIT);
      chk("R2", "table depth 10 turn", cur_ofs(), -9);
      base_div = 11'd1000;
   endtask

   task automatic t_disable();
      restart(1'b1, 4'd2, 4'b1101, 6'd1);
      edges(2 * UNIT);
      chk("R1", "pre-disable offset", cur_ofs(), 2);
      spread_en = 1'b0;
      #1;
      chk("R1", "div passes when off", int'(div_out), 1000);
      edges(3);
      spread_en = 1'b1;
      edges(UNIT);
      chk("R1", "restart upward from 0", cur_ofs(), 1);
   endtask

   task automatic t_dwell();
      restart(1'b1, 4'd3, 4'b1111, 6'd2);
      edges(2 * UNIT - 1);
      chk("R5", "dwell 2 early", cur_ofs(), 0);
      edges(1);
      chk("R5", "dwell 2 step", cur_ofs(), 1);
      dwell = 6'd0;
      edges(300);
      chk("R5", "dwell 0 freezes", cur_ofs(), 1);
      restart(1'b1, 4'd3, 4'b1111, 6'd0);
      edges(500);
      chk("R5", "dwell 0 from start", cur_ofs(), 0);
   endtask

   task automatic t_sata();
      sata_spread_en = 1'b0;
      restart(1'b1, 4'd3, 4'b1111, 6'd1);
      edges(2 * UNIT);
      chk("R6", "sata bypass", int'(sata_div_out), 500);
      chk("R6", "main modulated", cur_ofs(), 2);
      sata_spread_en = 1'b1;
      #1;
      chk("R6", "sata follows", int'(sata_div_out), 502);
      spread_en = 1'b0;
      #1;
      chk("R6", "sata off with global", int'(sata_div_out), 500);
      sata_spread_en = 1'b0;
   endtask

   task automatic t_zero();
      restart(1'b1, 4'd0, 4'b0000, 6'd1);
      edges(5 * UNIT);
      chk("R7", "zero limits hold", cur_ofs(), 0);
   endtask

   task automatic t_base();
      restart(1'b1, 4'd3, 4'b1111, 6'd1);
      edges(2 * UNIT);
      base_div = 11'd1234;
      #1;
      chk("R8", "base change same cycle", int'(div_out), 1236);
      base_div = 11'd0;
      restart(1'b1, 4'd0, 4'b1111, 6'd1);
      edges(UNIT);
      chk("R8", "wrap below zero", int'(div_out), 2047);
      base_div = 11'd1000;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_walk();
      t_decode();
      t_table();
      t_disable();
      t_dwell();
      t_sata();
      t_zero();
      t_base();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles expected completion", 150000);
      finish_run();
   end
endmodule